// File: doc/BRIEF.md
# CPU-Cycle Interrupt Up-Counter

This block is a free-running up-counter, 15 bits wide by default, that advances once on every CPU cycle. When an increment carries it to its all-ones terminal value, it raises an interrupt line. The CPU works directly on the live count through two byte-wide register windows. No reload value exists: whatever software writes is the count itself, and whatever it reads is the count at that moment.

One window carries the low count byte. The other carries the remaining upper count bits together with an interrupt enable flag in its top bit. At the terminal value the counter stops and holds there until software writes a new count. The interrupt line stays high until the CPU touches either register window, and any such touch acknowledges it. A typical use is to preload a count, set the enable, and take the interrupt a known number of cycles later.

Top module: `cyc_irq_counter`

## Requirements
- R1: After reset the count is 0, the enable flag is 0 and `irq_o` is low.
- R2: While `cpu_ce_i`=1, a write (`cpu_rw_i`=0) anywhere in 0x5000–0x57FF loads `cpu_data_i` into count bits 7:0 and leaves the upper count bits unchanged. `cpu_rd_data_o` for an address in that window shows count bits 7:0.
- R3: While `cpu_ce_i`=1, a write anywhere in 0x5800–0x5FFF loads data bits 6:0 into count bits 14:8 and data bit 7 into the enable flag (1 = enabled). A read of that window shows {enable, count[14:8]}.
- R4: `cpu_rd_data_o` depends only on `cpu_addr_i` and the stored state. It reads 0 outside both windows. A write while `cpu_ce_i`=0, or a write to an address outside both windows, changes no register.
- R5: Every `cpu_ce_i` cycle that is not a counter-register write adds one to the count, with carry into the upper bits. The count holds while `cpu_ce_i`=0.
- R6: In a cycle that writes a counter register, the written value is what is stored. No increment is applied in that cycle.
- R7: `irq_o` rises at the clock edge where an increment takes the count to 0x7FFF while the enable is 1. Writing 0x7FFF directly does not raise it.
- R8: At 0x7FFF the count stops until it is written. `irq_o` stays high until acknowledged and does not rise again while the count is held.
- R9: A read or a write of either window with `cpu_ce_i`=1 clears `irq_o` at the end of that cycle. A read in the same cycle in which the count reaches 0x7FFF leaves `irq_o` set.
- R10: With the enable at 0, reaching 0x7FFF does not raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_rw_i | input | 1 | 1 = read, 0 = write |
| cpu_ce_i | input | 1 | CPU cycle enable; qualifies counting and register access |
| cpu_rd_data_o | output | 8 | Read-back data for the addressed window |
| irq_o | output | 1 | Interrupt request, active high, held until acknowledged |

## Verification
The bench builds the block with its default parameters: a 15-bit count, 16-bit addresses and 2 KB windows. These values make every low byte, every high-register value and every alias address in both windows cheap to sweep. They also make one uninterrupted run from zero to the terminal value fit comfortably in the cycle budget. Near the terminal value, directed sequences cover the arrival edge, saturation, acknowledgement by read and by write, and a read that coincides with the arrival.

// File: rtl/cyc_irq_pkg.sv
package cyc_irq_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/cyc_irq_decode.sv
module cyc_irq_decode
  import cyc_irq_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int          WIN_W   = 11,
  parameter logic [15:0] LO_BASE = 16'h5000,
  parameter logic [15:0] HI_BASE = 16'h5800
) (
  input  logic [ADDR_W-WIN_W-1:0] page_i,
  output reg_sel_e                sel_o
);
  localparam int PAGE_W = ADDR_W - WIN_W;
  localparam int N_WIN  = 2;

  logic [N_WIN-1:0] hit;

  function automatic logic [PAGE_W-1:0] win_page(input int idx);
    logic [15:0] base;
    base = (idx == 0) ? LO_BASE : HI_BASE;
    return base[ADDR_W-1:WIN_W];
  endfunction

  for (genvar i = 0; i < N_WIN; i++) begin : g_win
    assign hit[i] = (page_i == win_page(i));
  end

  always_comb begin
    unique case (hit)
      2'b01:   sel_o = SEL_LO;
      2'b10:   sel_o = SEL_HI;
      default: sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/cyc_irq_count.sv
module cyc_irq_count #(
  parameter int CNT_W  = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              en_o,
  output logic              reach_o
);
  localparam int HI_W = CNT_W - DATA_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_PRE = CNT_MAX - 1'b1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en_q, en_d;
  logic             at_max, step;

  assign at_max = (cnt_q == CNT_MAX);
  // increment only on a live cycle that is not a register write
  assign step   = ce_i && !wr_lo_i && !wr_hi_i && !at_max;

  always_comb begin
    cnt_d = cnt_q;
    en_d  = en_q;
    if (wr_lo_i) begin
      cnt_d[DATA_W-1:0] = data_i;
    end else if (wr_hi_i) begin
      cnt_d[CNT_W-1:DATA_W] = data_i[HI_W-1:0];
      en_d                  = data_i[DATA_W-1];
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= en_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign en_o    = en_q;
  assign reach_o = step && (cnt_q == CNT_PRE);
endmodule

// File: rtl/cyc_irq_flag.sv
module cyc_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reach_i,
  input  logic en_i,
  input  logic ack_i,
  output logic irq_o
);
  logic irq_q;

  // arrival wins over a read ack in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               irq_q <= 1'b0;
    else if (reach_i && en_i)  irq_q <= 1'b1;
    else if (ack_i)            irq_q <= 1'b0;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/cyc_irq_rdmux.sv
module cyc_irq_rdmux
  import cyc_irq_pkg::*;
#(
  parameter int CNT_W  = 15,
  parameter int DATA_W = 8
) (
  input  reg_sel_e          sel_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              en_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [DATA_W-1:0] hi_word;

  always_comb begin
    hi_word             = '0;
    hi_word[HI_W-1:0]   = cnt_i[CNT_W-1:DATA_W];
    hi_word[DATA_W-1]   = en_i;
  end

  always_comb begin
    unique case (sel_i)
      SEL_LO:  data_o = cnt_i[DATA_W-1:0];
      SEL_HI:  data_o = hi_word;
      default: data_o = '0;
    endcase
  end
endmodule

// File: rtl/cyc_irq_counter.sv
module cyc_irq_counter
  import cyc_irq_pkg::*;
#(
  parameter int          CNT_W   = 15,
  parameter int          DATA_W  = 8,
  parameter int          ADDR_W  = 16,
  parameter int          WIN_W   = 11,
  parameter logic [15:0] LO_BASE = 16'h5000,
  parameter logic [15:0] HI_BASE = 16'h5800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  input  logic              cpu_rw_i,
  input  logic              cpu_ce_i,
  output logic [DATA_W-1:0] cpu_rd_data_o,
  output logic              irq_o
);
  reg_sel_e         sel;
  logic             acc, wr_lo, wr_hi, wr_any;
  logic [CNT_W-1:0] cnt_q;
  logic             en_q, reach;

  cyc_irq_decode #(
    .ADDR_W (ADDR_W),
    .WIN_W  (WIN_W),
    .LO_BASE(LO_BASE),
    .HI_BASE(HI_BASE)
  ) u_dec (
    .page_i(cpu_addr_i[ADDR_W-1:WIN_W]),
    .sel_o (sel)
  );

  assign acc    = cpu_ce_i && (sel != SEL_NONE);
  assign wr_lo  = cpu_ce_i && !cpu_rw_i && (sel == SEL_LO);
  assign wr_hi  = cpu_ce_i && !cpu_rw_i && (sel == SEL_HI);
  assign wr_any = wr_lo || wr_hi;

  cyc_irq_count #(
    .CNT_W (CNT_W),
    .DATA_W(DATA_W)
  ) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_i   (cpu_ce_i),
    .wr_lo_i(wr_lo),
    .wr_hi_i(wr_hi),
    .data_i (cpu_data_i),
    .cnt_o  (cnt_q),
    .en_o   (en_q),
    .reach_o(reach)
  );

  cyc_irq_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .reach_i(reach),
    .en_i   (en_q),
    .ack_i  (acc),
    .irq_o  (irq_o)
  );

  cyc_irq_rdmux #(
    .CNT_W (CNT_W),
    .DATA_W(DATA_W)
  ) u_rd (
    .sel_i (sel),
    .cnt_i (cnt_q),
    .en_i  (en_q),
    .data_o(cpu_rd_data_o)
  );
endmodule

// File: rtl/cyc_irq_counter_chk.sv
module cyc_irq_counter_chk #(
  parameter int CNT_W  = 15,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_i,
  input logic              wr_lo_i,
  input logic              wr_any_i,
  input logic [DATA_W-1:0] data_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              en_i,
  input logic              irq_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(cnt_i) && $stable(en_i));

  p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !wr_any_i && cnt_i != CNT_MAX) |=> cnt_i == CNT_W'($past(cnt_i) + 1'b1));

  p_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> cnt_i[DATA_W-1:0] == $past(data_i));

  p_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> (cnt_i == CNT_MAX) && $past(en_i));

  p_sat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_any_i && cnt_i == CNT_MAX) |=> cnt_i == CNT_MAX);

  p_wr_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_any_i |=> !irq_i);

  p_no_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !irq_i) |=> !irq_i);
endmodule

bind cyc_irq_counter cyc_irq_counter_chk #(
  .CNT_W (CNT_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ce_i    (cpu_ce_i),
  .wr_lo_i (wr_lo),
  .wr_any_i(wr_any),
  .data_i  (cpu_data_i),
  .cnt_i   (cnt_q),
  .en_i    (en_q),
  .irq_i   (irq_o)
);

// File: tb/cyc_irq_counter_tb.sv
`timescale 1ns/1ps
module cyc_irq_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rw = 1'b1;
  logic        ce = 1'b0;
  logic [7:0]  rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cyc_irq_counter u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cpu_addr_i   (addr),
    .cpu_data_i   (wdata),
    .cpu_rw_i     (rw),
    .cpu_ce_i     (ce),
    .cpu_rd_data_o(rdata),
    .irq_o        (irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; rw = 1'b0; ce = 1'b1;
    @(posedge clk); #1;
    ce = 1'b0; rw = 1'b1;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rw = 1'b1; ce = 1'b1;
    #1 d = rdata;
    @(posedge clk); #1;
    ce = 1'b0;
  endtask

  task automatic peek(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; ce = 1'b0; rw = 1'b1;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      addr = 16'h0000; rw = 1'b1; ce = 1'b1;
      @(posedge clk); #1;
    end
    ce = 1'b0;
  endtask

  task automatic get_cnt(output int c, output bit en);
    logic [7:0] lo, hi;
    peek(16'h5000, lo);
    peek(16'h5800, hi);
    c  = {hi[6:0], lo};
    en = hi[7];
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int c; bit en; logic [7:0] d; bit ok;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    get_cnt(c, en);
    check(c == 0, "R1 count", c, 0);
    check(en == 1'b0, "R1 enable", en, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);

    // R2 low byte sweep through aliased addresses; R6 no increment on write
    wr(16'h5800, 8'h2A);
    ok = 1'b1;
    for (int v = 0; v < 256; v++) begin
      wr(16'h5000 + 16'(v * 8), 8'(v));
      get_cnt(c, en);
      if (c != ((16'h2A << 8) | v)) begin ok = 1'b0; check(1'b0, "R2 low sweep", c, (16'h2A << 8) | v); end
    end
    check(ok, "R2 low sweep all", 0, 0);
    check(ok, "R6 write cycle stores value", 0, 0);

    // R3 high register sweep, low byte kept
    ok = 1'b1;
    for (int v = 0; v < 256; v++) begin
      wr(16'h5FFF - 16'(v * 8), 8'(v));
      peek(16'h5800, d);
      if (d != 8'(v)) begin ok = 1'b0; check(1'b0, "R3 high readback", d, v); end
      peek(16'h5000, d);
      if (d != 8'hFF) begin ok = 1'b0; check(1'b0, "R3 low kept", d, 8'hFF); end
    end
    check(ok, "R3 high sweep all", 0, 0);
    check(irq == 1'b0, "R7 direct write of max no irq", irq, 0);

    // R4 aliasing over full windows, outside reads zero, ignored writes
    wr(16'h5800, 8'h35);
    wr(16'h5000, 8'h9A);
    ok = 1'b1;
    for (int off = 0; off < 2048; off++) begin
      peek(16'h5000 + 16'(off), d);
      if (d != 8'h9A) ok = 1'b0;
      peek(16'h5800 + 16'(off), d);
      if (d != 8'h35) ok = 1'b0;
    end
    check(ok, "R4 alias windows", 0, 0);
    peek(16'h4FFF, d); check(d == 0, "R4 below window", d, 0);
    peek(16'h6000, d); check(d == 0, "R4 above window", d, 0);
    wr(16'h4FFF, 8'h00);
    get_cnt(c, en);
    check(c == 16'h359B, "R4 outside write ignored (one count step)", c, 16'h359B);
    @(negedge clk); addr = 16'h5000; wdata = 8'h11; rw = 1'b0; ce = 1'b0;
    @(posedge clk); #1 rw = 1'b1;
    get_cnt(c, en);
    check(c == 16'h359B, "R4 write without ce ignored", c, 16'h359B);

    // R5 increments, carry, hold with ce low
    wr(16'h5800, 8'h12);
    wr(16'h5000, 8'h34);
    idle(100);
    get_cnt(c, en);
    check(c == 16'h1234 + 100, "R5 count after 100 cycles", c, 16'h1234 + 100);
    repeat (20) @(posedge clk);
    get_cnt(c, en);
    check(c == 16'h1234 + 100, "R5 hold with ce low", c, 16'h1234 + 100);
    wr(16'h5800, 8'h00);
    wr(16'h5000, 8'hFF);
    idle(1);
    get_cnt(c, en);
    check(c == 16'h0100, "R5 carry into high", c, 16'h0100);

    // R7 arrival edge
    wr(16'h5800, 8'hFF);
    wr(16'h5000, 8'hFD);
    idle(1);
    check(irq == 1'b0, "R7 irq before max", irq, 0);
    idle(1);
    check(irq == 1'b1, "R7 irq at max", irq, 1);
    get_cnt(c, en);
    check(c == 16'h7FFF, "R7 count at max", c, 16'h7FFF);

    // R8 saturation and sticky irq
    idle(10);
    get_cnt(c, en);
    check(c == 16'h7FFF, "R8 saturate", c, 16'h7FFF);
    check(irq == 1'b1, "R8 irq held", irq, 1);

    // R9 read ack, no re-raise while held
    rd(16'h5000, d);
    check(d == 8'hFF, "R9 read data", d, 8'hFF);
    check(irq == 1'b0, "R9 read ack", irq, 0);
    idle(5);
    check(irq == 1'b0, "R8 no re-raise while held", irq, 0);
    wr(16'h5000, 8'hFE);
    idle(1);
    check(irq == 1'b1, "R9 rearm", irq, 1);
    wr(16'h5FFF, 8'hFF);
    check(irq == 1'b0, "R9 write ack", irq, 0);
    wr(16'h5000, 8'hFE);
    idle(1);
    rd(16'h5ABC, d);
    check(irq == 1'b0, "R9 aliased read ack", irq, 0);

    // R9 read coinciding with arrival keeps irq
    wr(16'h5000, 8'hFE);
    rd(16'h5000, d);
    check(d == 8'hFE, "R9 read before arrival", d, 8'hFE);
    check(irq == 1'b1, "R9 arrival beats read ack", irq, 1);
    rd(16'h5800, d);

    // R10 enable low
    wr(16'h5800, 8'h7F);
    wr(16'h5000, 8'hFD);
    idle(3);
    get_cnt(c, en);
    check(c == 16'h7FFF, "R10 count reached max", c, 16'h7FFF);
    check(irq == 1'b0, "R10 no irq when disabled", irq, 0);

    // R5/R7 full run from zero
    wr(16'h5800, 8'h80);
    wr(16'h5000, 8'h00);
    idle(32766);
    check(irq == 1'b0, "R7 full run before max", irq, 0);
    get_cnt(c, en);
    check(c == 16'h7FFE, "R5 full run count", c, 16'h7FFE);
    idle(1);
    check(irq == 1'b1, "R7 full run irq", irq, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule